// File: doc/BRIEF.md
# Bank-Aware Read/Write Request Scheduler with Batched Write Drain

This block sits between a memory request source and a DRAM command engine. Each bank has two queues, one for reads and one for writes. For each bank, the block picks the next request so that requests to the row already open in that bank go first. Once the block starts serving a row, it keeps serving that row until no request for it is left. When no queued request matches, the oldest request is chosen and the pick is marked as a row miss.

A single global mode decides whether the read queues or the write queues are served. The mode moves to writing when the number of pending writes reaches a high watermark, or when the strobed bank has writes but no reads. It moves back to reading when pending writes drop below a low watermark, or when the strobed bank has reads but no writes. Because of these rules, writes leave in batches and do not interleave with reads. When the `SPLIT` parameter is cleared, writes go into the read queues and only the read capacity applies.

The producer calls the enqueue port and watches the two full flags. The command engine strobes a bank together with that bank's currently open row. The chosen request appears on the issue port one cycle later.

Top module: `drs_sched`

## Requirements
- R1: After reset the block is in read mode (`write_mode`=0), `iss_valid` is 0, and both full flags are 0. The mode changes only on a cycle with `sch_valid`=1.
- R2: An accepted enqueue with `enq_write`=1 goes to the write class and raises the pending-write count. Any other accepted enqueue raises the pending-read count. `wr_full`=1 exactly when pending writes equal `WR_CAP` (default 32). `rd_full`=1 exactly when pending reads equal `RD_CAP` (default 16).
- R3: An enqueue into a class whose full flag is set is dropped. In that same cycle `enq_err`=1, and the dropped request is never issued.
- R4: When the selected queue has no row in progress and holds a request whose row equals `sch_open_row`, the oldest such request is issued with `iss_row_miss`=0.
- R5: When the selected queue has no row in progress and no request matches the open row, its oldest request is issued with `iss_row_miss`=1. That request's row becomes the row in progress.
- R6: While a row is in progress, each strobe issues the oldest remaining request of that row, whatever the open row is, with `iss_row_miss`=0. After the last request of that row is issued, the row in progress clears.
- R7: In read mode, a strobe taken when pending writes are at or above `HI_MARK` (default 28) switches to write mode and serves the write queue.
- R8: In read mode, a strobe to a bank whose read queue is empty and whose write queue is not switches to write mode.
- R9: In write mode, a strobe switches to read mode when pending writes are below `LO_MARK` (default 16), or when the bank has reads but no writes.
- R10: If the queue chosen by the mode is empty for the strobed bank, `iss_valid` stays 0 in the cycle after the strobe.
- R11: Each bank keeps a separate row-in-progress for reads and for writes, and a mode change does not clear either one.
- R12: The outputs `iss_valid`, `iss_bank`, `iss_row`, `iss_write`, `iss_tag` and `iss_row_miss` hold the pick made by the strobe one clock earlier. An enqueue and an issue in the same cycle, even on the same queue, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally on release |
| enq_valid | input | 1 | Enqueue request |
| enq_bank | input | $clog2(BANKS) | Target bank |
| enq_row | input | ROW_W | Target row |
| enq_write | input | 1 | 1 = write request |
| enq_tag | input | TAG_W | Request tag |
| enq_err | output | 1 | Enqueue dropped because its class is full |
| rd_full | output | 1 | Read class at capacity |
| wr_full | output | 1 | Write class at capacity |
| sch_valid | input | 1 | Schedule strobe |
| sch_bank | input | $clog2(BANKS) | Bank being scheduled |
| sch_open_row | input | ROW_W | Row currently open in that bank |
| iss_valid | output | 1 | Issued request valid |
| iss_bank | output | $clog2(BANKS) | Bank of the issued request |
| iss_row | output | ROW_W | Row of the issued request |
| iss_write | output | 1 | Issued request is a write |
| iss_tag | output | TAG_W | Tag of the issued request |
| iss_row_miss | output | 1 | Pick opened a new row |
| write_mode | output | 1 | Current global mode, 1 = write |

## Verification
The hardest state to reach is a write row in progress that stays alive through a switch back to read mode and then resumes when the block re-enters write mode, while another write that matches the open row is waiting. The stimulus creates this by issuing one write of a two-entry row, pulling the block into read mode with a single read, adding a newer write that hits the open row, and strobing again. The watermark path needs 32 queued writes. Draining them shows the low-watermark hand-back to a waiting read and the alternating issue/empty strobes that follow. The same drain confirms that a write dropped while the class was full never appears at the issue port.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } drs_mode_e;
endpackage

// File: rtl/drs_mode_ctl.sv
module drs_mode_ctl
  import drs_pkg::*;
#(
  parameter int PEND_W  = 6,
  parameter int HI_MARK = 28,
  parameter int LO_MARK = 16,
  parameter bit SPLIT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [PEND_W-1:0] wr_pend,
  input  logic              bank_rd_empty,
  input  logic              bank_wr_empty,
  output drs_mode_e         mode_now,
  output drs_mode_e         mode_q
);

  always_comb begin
    mode_now = mode_q;
    if (strobe && SPLIT) begin
      if (mode_q == MODE_RD) begin
        if (wr_pend >= PEND_W'(HI_MARK) || (bank_rd_empty && !bank_wr_empty))
          mode_now = MODE_WR;
      end else begin
        if (wr_pend < PEND_W'(LO_MARK) || (!bank_rd_empty && bank_wr_empty))
          mode_now = MODE_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_RD;
    else if (strobe) mode_q <= mode_now;
  end

  // R7
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SPLIT && strobe && mode_q == MODE_RD && wr_pend >= PEND_W'(HI_MARK)) |=> mode_q == MODE_WR);

  // R9
  lo_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SPLIT && strobe && mode_q == MODE_WR && wr_pend < PEND_W'(LO_MARK)) |=> mode_q == MODE_RD);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(strobe));

endmodule

// File: rtl/drs_rowq.sv
module drs_rowq #(
  parameter int DEPTH = 16,
  parameter int ROW_W = 8,
  parameter int PL_W  = 9,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ROW_W-1:0] push_row,
  input  logic [PL_W-1:0]  push_pl,
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  input  logic [ROW_W-1:0] q_row,
  output logic             q_hit,
  output logic [IDX_W-1:0] q_idx,
  output logic             q_multi,
  output logic [ROW_W-1:0] head_row,
  output logic             head_dup,
  output logic [PL_W-1:0]  sel_pl,
  output logic [CNT_W-1:0] count
);

  logic [ROW_W-1:0] row_q [DEPTH];
  logic [ROW_W-1:0] row_d [DEPTH];
  logic [PL_W-1:0]  pl_q  [DEPTH];
  logic [PL_W-1:0]  pl_d  [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, wptr, q_matches, h_matches;

  // oldest entry is at index 0; search favours the lowest index
  always_comb begin
    q_hit     = 1'b0;
    q_idx     = '0;
    q_matches = '0;
    h_matches = '0;
    sel_pl    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt_q && row_q[i] == q_row) begin
        q_hit     = 1'b1;
        q_idx     = IDX_W'(i);
        q_matches = q_matches + CNT_W'(1);
      end
    end
    for (int i = 1; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_q && row_q[i] == row_q[0]) h_matches = h_matches + CNT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (IDX_W'(i) == pop_idx) sel_pl = pl_q[i];
    end
  end

  assign q_multi  = q_matches > CNT_W'(1);
  assign head_row = row_q[0];
  assign head_dup = h_matches != '0;
  assign count    = cnt_q;

  // compaction on removal, then append behind the survivors
  always_comb begin
    row_d = row_q;
    pl_d  = pl_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) begin
          row_d[i] = row_q[i+1];
          pl_d[i]  = pl_q[i+1];
        end
      end
    end
    wptr = cnt_q - CNT_W'(pop);
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == wptr) begin
          row_d[i] = push_row;
          pl_d[i]  = push_pl;
        end
      end
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (push || pop) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push || pop) begin
      row_q <= row_d;
      pl_q  <= pl_d;
    end
  end

  // R2
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);

  // R3
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q - CNT_W'(pop)) < CNT_W'(DEPTH));

endmodule

// File: rtl/drs_sched.sv
module drs_sched
  import drs_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 8,
  parameter int TAG_W   = 8,
  parameter int RD_CAP  = 16,
  parameter int WR_CAP  = 32,
  parameter int HI_MARK = 28,
  parameter int LO_MARK = 16,
  parameter bit SPLIT   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_valid,
  input  logic [$clog2(BANKS)-1:0] enq_bank,
  input  logic [ROW_W-1:0]         enq_row,
  input  logic                     enq_write,
  input  logic [TAG_W-1:0]         enq_tag,
  output logic                     enq_err,
  output logic                     rd_full,
  output logic                     wr_full,
  input  logic                     sch_valid,
  input  logic [$clog2(BANKS)-1:0] sch_bank,
  input  logic [ROW_W-1:0]         sch_open_row,
  output logic                     iss_valid,
  output logic [$clog2(BANKS)-1:0] iss_bank,
  output logic [ROW_W-1:0]         iss_row,
  output logic                     iss_write,
  output logic [TAG_W-1:0]         iss_tag,
  output logic                     iss_row_miss,
  output logic                     write_mode
);

  localparam int BANK_W  = $clog2(BANKS);
  localparam int MAX_CAP = (RD_CAP > WR_CAP) ? RD_CAP : WR_CAP;
  localparam int IDX_W   = $clog2(MAX_CAP);
  localparam int CNT_W   = $clog2(MAX_CAP + 1);
  localparam int PL_W    = TAG_W + 1;
  localparam int RP_W    = $clog2(RD_CAP + 1);
  localparam int WP_W    = $clog2(WR_CAP + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // per class (0 read, 1 write) and bank
  logic             q_hit_a   [2][BANKS];
  logic [IDX_W-1:0] q_idx_a   [2][BANKS];
  logic             q_multi_a [2][BANKS];
  logic [ROW_W-1:0] head_row_a[2][BANKS];
  logic             head_dup_a[2][BANKS];
  logic [PL_W-1:0]  sel_pl_a  [2][BANKS];
  logic [CNT_W-1:0] cnt_a     [2][BANKS];
  logic             push_a    [2][BANKS];
  logic             pop_a     [2][BANKS];
  logic             str_v_q   [2][BANKS];
  logic             str_v_d   [2][BANKS];
  logic [ROW_W-1:0] str_row_q [2][BANKS];
  logic [ROW_W-1:0] str_row_d [2][BANKS];

  logic [RP_W-1:0]  rd_pend_q, rd_pend_d;
  logic [WP_W-1:0]  wr_pend_q, wr_pend_d;
  drs_mode_e        mode_now, mode_q;
  logic             enq_cls, enq_ok, pk_cls, issue, pk_miss, pk_remain;
  logic [IDX_W-1:0] pk_idx;
  logic [ROW_W-1:0] pk_row;

  // admission
  assign enq_cls = SPLIT && enq_write;
  assign rd_full = rd_pend_q >= RP_W'(RD_CAP);
  assign wr_full = SPLIT ? (wr_pend_q >= WP_W'(WR_CAP)) : rd_full;
  assign enq_err = enq_valid && (enq_cls ? wr_full : rd_full);
  assign enq_ok  = enq_valid && !enq_err;

  drs_mode_ctl #(
    .PEND_W(WP_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .SPLIT(SPLIT)
  ) mode_i (
    .clk(clk), .rst_n(rst_i), .strobe(sch_valid), .wr_pend(wr_pend_q),
    .bank_rd_empty(cnt_a[0][sch_bank] == '0),
    .bank_wr_empty(cnt_a[1][sch_bank] == '0),
    .mode_now(mode_now), .mode_q(mode_q)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    for (genvar c = 0; c < 2; c++) begin : g_cls
      assign push_a[c][g] = enq_ok && (enq_bank == BANK_W'(g)) && (enq_cls == c[0]);
      assign pop_a[c][g]  = issue && (sch_bank == BANK_W'(g)) && (pk_cls == c[0]);
      if (c == 0 || SPLIT) begin : g_q
        drs_rowq #(
          .DEPTH(c == 0 ? RD_CAP : WR_CAP), .ROW_W(ROW_W), .PL_W(PL_W),
          .IDX_W(IDX_W), .CNT_W(CNT_W)
        ) q_i (
          .clk(clk), .rst_n(rst_i),
          .push(push_a[c][g]), .push_row(enq_row), .push_pl({enq_write, enq_tag}),
          .pop(pop_a[c][g]), .pop_idx(pk_idx),
          .q_row(str_v_q[c][g] ? str_row_q[c][g] : sch_open_row),
          .q_hit(q_hit_a[c][g]), .q_idx(q_idx_a[c][g]), .q_multi(q_multi_a[c][g]),
          .head_row(head_row_a[c][g]), .head_dup(head_dup_a[c][g]),
          .sel_pl(sel_pl_a[c][g]), .count(cnt_a[c][g])
        );
      end else begin : g_none
        assign q_hit_a[c][g]    = 1'b0;
        assign q_idx_a[c][g]    = '0;
        assign q_multi_a[c][g]  = 1'b0;
        assign head_row_a[c][g] = '0;
        assign head_dup_a[c][g] = 1'b0;
        assign sel_pl_a[c][g]   = '0;
        assign cnt_a[c][g]      = '0;
      end
    end
  end

  // pick within the strobed bank and the class the mode selects
  always_comb begin
    pk_cls = (mode_now == MODE_WR);
    issue  = sch_valid && (cnt_a[pk_cls][sch_bank] != '0);
    if (str_v_q[pk_cls][sch_bank]) begin
      pk_idx    = q_idx_a[pk_cls][sch_bank];
      pk_row    = str_row_q[pk_cls][sch_bank];
      pk_miss   = 1'b0;
      pk_remain = q_multi_a[pk_cls][sch_bank];
    end else if (q_hit_a[pk_cls][sch_bank]) begin
      pk_idx    = q_idx_a[pk_cls][sch_bank];
      pk_row    = sch_open_row;
      pk_miss   = 1'b0;
      pk_remain = q_multi_a[pk_cls][sch_bank];
    end else begin
      pk_idx    = '0;
      pk_row    = head_row_a[pk_cls][sch_bank];
      pk_miss   = 1'b1;
      pk_remain = head_dup_a[pk_cls][sch_bank];
    end
  end

  always_comb begin
    str_v_d   = str_v_q;
    str_row_d = str_row_q;
    if (issue) begin
      str_v_d[pk_cls][sch_bank]   = pk_remain;
      str_row_d[pk_cls][sch_bank] = pk_row;
    end
    rd_pend_d = rd_pend_q + RP_W'(enq_ok && !enq_cls) - RP_W'(issue && !pk_cls);
    wr_pend_d = wr_pend_q + WP_W'(enq_ok && enq_cls) - WP_W'(issue && pk_cls);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int c = 0; c < 2; c++) begin
        for (int b = 0; b < BANKS; b++) begin
          str_v_q[c][b]   <= 1'b0;
          str_row_q[c][b] <= '0;
        end
      end
      rd_pend_q    <= '0;
      wr_pend_q    <= '0;
      iss_valid    <= 1'b0;
      iss_bank     <= '0;
      iss_row      <= '0;
      iss_write    <= 1'b0;
      iss_tag      <= '0;
      iss_row_miss <= 1'b0;
    end else begin
      if (issue) begin
        str_v_q   <= str_v_d;
        str_row_q <= str_row_d;
      end
      if (enq_ok || issue) begin
        rd_pend_q <= rd_pend_d;
        wr_pend_q <= wr_pend_d;
      end
      iss_valid <= issue;
      if (issue) begin
        iss_bank     <= sch_bank;
        iss_row      <= pk_row;
        iss_write    <= sel_pl_a[pk_cls][sch_bank][TAG_W];
        iss_tag      <= sel_pl_a[pk_cls][sch_bank][TAG_W-1:0];
        iss_row_miss <= pk_miss;
      end
    end
  end

  assign write_mode = (mode_q == MODE_WR);

  // R12
  iss_src_chk: assert property (@(posedge clk) disable iff (!rst_i)
    iss_valid |-> $past(sch_valid));

  // R2
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wr_pend_q <= WP_W'(WR_CAP) && rd_pend_q <= RP_W'(RD_CAP));

  // R3
  drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (enq_err && !issue) |=> ($stable(rd_pend_q) && $stable(wr_pend_q)));

endmodule

// File: tb/drs_sched_tb_top.sv
`timescale 1ns/100ps
module drs_sched_tb_top;

  logic       clk;
  logic       rst_n;
  logic       enq_valid, enq_write, enq_err, rd_full, wr_full;
  logic [1:0] enq_bank, sch_bank, iss_bank;
  logic [7:0] enq_row, enq_tag, sch_open_row, iss_row, iss_tag;
  logic       sch_valid, iss_valid, iss_write, iss_row_miss, write_mode;

  drs_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_bank(enq_bank), .enq_row(enq_row),
    .enq_write(enq_write), .enq_tag(enq_tag), .enq_err(enq_err),
    .rd_full(rd_full), .wr_full(wr_full),
    .sch_valid(sch_valid), .sch_bank(sch_bank), .sch_open_row(sch_open_row),
    .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_row(iss_row),
    .iss_write(iss_write), .iss_tag(iss_tag), .iss_row_miss(iss_row_miss),
    .write_mode(write_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    due;
    bit    v;
    int    key;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int mk_key(input bit w, input int b, input int r, input int t, input bit m);
    return (int'(w) << 24) | (b << 20) | (r << 12) | (t << 4) | int'(m);
  endfunction

  // monitor: compares the issue port against the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t it;
      int   act;
      it  = exp_q.pop_front();
      act = mk_key(iss_write, int'(iss_bank), int'(iss_row), int'(iss_tag), iss_row_miss);
      if (!it.v)
        check(iss_valid == 1'b0, it.req, "iss_valid", int'(iss_valid), 0);
      else
        check(iss_valid && act == it.key, it.req, "issue", iss_valid ? act : -1, it.key);
    end
  end

  task automatic drive(input bit e, input int eb, input int er, input bit ew, input int et,
                       input bit s, input int sb, input int sr);
    @(negedge clk);
    enq_valid    = e;
    enq_bank     = 2'(eb);
    enq_row      = 8'(er);
    enq_write    = ew;
    enq_tag      = 8'(et);
    sch_valid    = s;
    sch_bank     = 2'(sb);
    sch_open_row = 8'(sr);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic enq(input int b, input int r, input bit w, input int t);
    drive(1, b, r, w, t, 0, 0, 0);
  endtask

  task automatic enq_chk(input int b, input int r, input bit w, input int t, input bit exp_err, input string req);
    drive(1, b, r, w, t, 0, 0, 0);
    #1 check(enq_err == exp_err, req, "enq_err", int'(enq_err), int'(exp_err));
  endtask

  task automatic push_exp(input bit v, input bit w, input int b, input int r, input int t, input bit m, input string req);
    exp_t it;
    it.due = cyc + 1;
    it.v   = v;
    it.key = mk_key(w, b, r, t, m);
    it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic strobe(input int b, input int open, input bit v, input bit w, input int r, input int t,
                        input bit m, input string req);
    drive(0, 0, 0, 0, 0, 1, b, open);
    push_exp(v, w, b, r, t, m, req);
  endtask

  task automatic strobe_enq(input int b, input int open, input bit v, input bit w, input int r, input int t,
                            input bit m, input string req, input int eb, input int er, input bit ew, input int et);
    drive(1, eb, er, ew, et, 1, b, open);
    push_exp(v, w, b, r, t, m, req);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    enq_valid = 0; enq_bank = 0; enq_row = 0; enq_write = 0; enq_tag = 0;
    sch_valid = 0; sch_bank = 0; sch_open_row = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    #1;
    // R1 reset state
    check(iss_valid == 0, "R1", "iss_valid", int'(iss_valid), 0);
    check(write_mode == 0, "R1", "write_mode", int'(write_mode), 0);
    check(rd_full == 0 && wr_full == 0, "R1", "full flags", int'({rd_full, wr_full}), 0);

    // reads on bank 0: open-row hit, oldest-row miss, row streaming
    enq(0, 5, 0, 1);
    enq(0, 7, 0, 2);
    enq(0, 5, 0, 3);
    enq(0, 9, 0, 4);
    strobe(0, 7, 1, 0, 7, 2, 0, "R4");
    strobe(0, 3, 1, 0, 5, 1, 1, "R5");
    strobe(0, 9, 1, 0, 5, 3, 0, "R6");
    strobe_enq(0, 9, 1, 0, 9, 4, 0, "R12", 0, 9, 0, 5);
    strobe(0, 9, 1, 0, 9, 5, 0, "R6");
    strobe(0, 0, 0, 0, 0, 0, 0, "R10");
    idle();
    #1 check(write_mode == 0, "R1", "write_mode held", int'(write_mode), 0);

    // bank 1: entering write mode on an empty read queue
    enq(1, 4, 1, 10);
    enq(1, 4, 1, 11);
    strobe(1, 4, 1, 1, 4, 10, 0, "R8");
    idle();
    #1 check(write_mode == 1, "R8", "write_mode", int'(write_mode), 1);
    enq(1, 6, 0, 12);
    strobe(1, 6, 1, 0, 6, 12, 0, "R9");
    idle();
    #1 check(write_mode == 0, "R9", "write_mode", int'(write_mode), 0);
    enq(1, 8, 1, 13);
    strobe(1, 8, 1, 1, 4, 11, 0, "R11");
    strobe(1, 2, 0, 0, 0, 0, 0, "R10");
    strobe(1, 2, 1, 1, 8, 13, 1, "R5");
    strobe(1, 2, 0, 0, 0, 0, 0, "R9");

    // bank 2: fill the write class, watermark drain
    enq(2, 1, 0, 20);
    for (int k = 0; k < 32; k++) enq(2, 3, 1, 30 + k);
    idle();
    #1 check(wr_full == 1, "R2", "wr_full", int'(wr_full), 1);
    check(rd_full == 0, "R2", "rd_full", int'(rd_full), 0);
    enq_chk(2, 3, 1, 62, 1, "R3");
    strobe(2, 1, 1, 1, 3, 30, 1, "R7");
    idle();
    #1 check(write_mode == 1 && wr_full == 0, "R7", "mode/wr_full", int'({write_mode, wr_full}), 2);
    for (int k = 1; k < 17; k++) strobe(2, 1, 1, 1, 3, 30 + k, 0, "R6");
    strobe(2, 1, 1, 0, 1, 20, 0, "R9");
    for (int k = 0; k < 15; k++) begin
      strobe(2, 1, 1, 1, 3, 47 + k, 0, "R11");
      strobe(2, 1, 0, 0, 0, 0, 0, "R10");
    end
    strobe(2, 3, 0, 0, 0, 0, 0, "R3");

    // bank 3: read class capacity
    for (int k = 0; k < 16; k++) enq(3, k, 0, 70 + k);
    idle();
    #1 check(rd_full == 1, "R2", "rd_full", int'(rd_full), 1);
    check(wr_full == 0, "R2", "wr_full", int'(wr_full), 0);
    enq_chk(3, 20, 0, 99, 1, "R3");
    enq_chk(3, 20, 1, 98, 0, "R2");
    repeat (3) idle();
    #1 check(exp_q.size() == 0, "R12", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule